// File: doc/BRIEF.md
# Saturating Q-format result view

This block sits between the stored product/accumulator of a hardware multiplier and the read bus. It never changes the stored value. Instead it builds, every cycle, an adjusted view of that value: optionally shifted left by one bit for fractional (Q-format) reads, and optionally clamped to the most positive or most negative number when the stored value has run out of range. The view appears on a word-wide read port, selected by a word index.

A second output carries the value handed back to the multiply-accumulate engine for the next accumulation. That path is clamped when saturation is on, but it ignores fractional mode. This keeps one extra bit of headroom during a chain of accumulations, so only the final read is limited.

An operand-size input chooses the clamp width. For the narrow (single-word by single-word) case only the low two words are clamped. For every wider case the full result is clamped, and the block flags the read as not valid until the multiplier reports that the top word is ready. All outputs are registered, so changing a mode bit changes the very next read.

Top module: `res_sat_view`

## Requirements
- R1: With saturation and fractional mode both off, one cycle after the inputs, `rd_data` equals word `rd_sel` of `raw_res` (word k is bits 16k+15 down to 16k), and `acc_fb` equals `raw_res`.
- R2: With fractional mode on and saturation off, the read view is `raw_res` shifted left by one bit across all 64 bits with a 0 entering bit 0. `acc_fb` stays equal to `raw_res`.
- R3: With saturation on, a carry of 0 together with a clamp-width MSB of 1 makes the read view the most positive value of the clamp width (0x7FFF in the top clamped word, 0xFFFF below). This holds whether or not fractional mode is on.
- R4: With saturation on, a carry of 1 together with a clamp-width MSB of 0 makes the read view the most negative value of the clamp width (0x8000 in the top clamped word, 0x0000 below).
- R5: With saturation and fractional mode on and no R3/R4 condition, the two top bits of the unshifted clamp-width value decide the result. 01 gives the most positive value, 10 gives the most negative value, and 00 or 11 give the shifted value.
- R6: When `narrow_op` is 1, the clamp width is 32 bits (words 0 and 1). Words 2 and 3 read the unclamped view (raw, or shifted with bit 31 moving into bit 32 in fractional mode). When `narrow_op` is 0, the clamp width is 64 bits.
- R7: With saturation on, `acc_fb` applies only the R3/R4 clamp at the clamp width, whatever fractional mode is. With saturation off, `acc_fb` is `raw_res`.
- R8: With saturation on, `narrow_op`=0 and `top_ready`=0, `rd_valid` is 0, `rd_data` returns the raw word and `acc_fb` is `raw_res`. In every other case `rd_valid` is 1, and `top_ready` has no effect when `narrow_op`=1.
- R9: While `rst` is high, `rd_data`, `rd_valid` and `acc_fb` are cleared to 0 at each rising clock edge.
- R10: A change of `sat_en` or `frac_en` alone, with the stored result unchanged, switches the read between the clamped and unclamped views at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| raw_res | input | 64 | Stored multiplier result, unmodified |
| carry_in | input | 1 | Result carry flag from the multiplier |
| sat_en | input | 1 | Saturation mode enable |
| frac_en | input | 1 | Fractional (shift-left-by-one) mode enable |
| narrow_op | input | 1 | 1: single-word operands, 32-bit clamp; 0: 64-bit clamp |
| top_ready | input | 1 | Top result word of a wide operation is ready |
| rd_sel | input | 2 | Index of the word to read |
| rd_data | output | 16 | Adjusted read word |
| rd_valid | output | 1 | Read word reflects a finished clamp decision |
| acc_fb | output | 64 | Adjusted value fed back for accumulation |

## Verification
Every output is a single register stage away from the inputs, so each result is due exactly one rising edge after the stimulus that causes it. The same holds for a mode-bit toggle and for the rise of `top_ready`. The bench changes inputs on a falling edge and samples on the following falling edge, which places every check half a cycle after the one register it passes through. Each scenario first settles a new input set, then walks the word index one step per cycle. This gives every word its own one-cycle window.

// File: rtl/res_sat_pkg.sv
package res_sat_pkg;

    localparam int DEF_WORD_W       = 16;
    localparam int DEF_NUM_WORDS    = 4;
    localparam int DEF_NARROW_WORDS = 2;

    // Clamp decision for one value
    typedef enum logic [1:0] {
        CLAMP_NONE = 2'd0,
        CLAMP_POS  = 2'd1,
        CLAMP_NEG  = 2'd2
    } clamp_e;

    // Mode bits as one datapath word
    typedef struct packed {
        logic sat;
        logic frac;
        logic narrow;
    } mode_t;

    // Out-of-range test from carry and MSB alone
    function automatic clamp_e carry_clamp(input logic carry, input logic msb);
        clamp_e c;
        if (!carry && msb)      c = CLAMP_POS;
        else if (carry && !msb) c = CLAMP_NEG;
        else                    c = CLAMP_NONE;
        return c;
    endfunction

    // Adds the shifted-view range test on top of the carry test
    function automatic clamp_e frac_clamp(input clamp_e base, input logic frac,
                                          input logic msb, input logic next);
        clamp_e c;
        if (base != CLAMP_NONE)          c = base;
        else if (frac && (msb != next))  c = msb ? CLAMP_NEG : CLAMP_POS;
        else                             c = CLAMP_NONE;
        return c;
    endfunction

endpackage

// File: rtl/res_clamp.sv
module res_clamp
    import res_sat_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] unshifted,
    input  logic [W-1:0] view_in,
    input  logic         carry,
    input  logic         frac,
    output logic [W-1:0] rd_out,
    output logic [W-1:0] acc_out
);

    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    clamp_e base_c;
    clamp_e read_c;

    assign base_c = carry_clamp(carry, unshifted[W-1]);
    assign read_c = frac_clamp(base_c, frac, unshifted[W-1], unshifted[W-2]);

    always_comb begin
        unique case (read_c)
            CLAMP_POS: rd_out = MOST_POS;
            CLAMP_NEG: rd_out = MOST_NEG;
            default:   rd_out = view_in;
        endcase
    end

    always_comb begin
        unique case (base_c)
            CLAMP_POS: acc_out = MOST_POS;
            CLAMP_NEG: acc_out = MOST_NEG;
            default:   acc_out = unshifted;
        endcase
    end

endmodule

// File: rtl/res_word_pick.sv
module res_word_pick #(
    parameter int WORD_W    = 16,
    parameter int NUM_WORDS = 4,
    parameter int SEL_W     = 2
) (
    input  logic [WORD_W*NUM_WORDS-1:0] view,
    input  logic [SEL_W-1:0]            sel,
    output logic [WORD_W-1:0]           word
);

    logic [WORD_W-1:0] words [NUM_WORDS];

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_split
        assign words[k] = view[k*WORD_W +: WORD_W];
    end

    always_comb begin
        word = '0;
        for (int k = 0; k < NUM_WORDS; k++) begin
            if (sel == SEL_W'(k)) word = words[k];
        end
    end

endmodule

// File: rtl/res_sat_view.sv
module res_sat_view
    import res_sat_pkg::*;
#(
    parameter int WORD_W       = DEF_WORD_W,
    parameter int NUM_WORDS    = DEF_NUM_WORDS,
    parameter int NARROW_WORDS = DEF_NARROW_WORDS,
    localparam int RES_W       = WORD_W * NUM_WORDS,
    localparam int SEL_W       = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RES_W-1:0]  raw_res,
    input  logic              carry_in,
    input  logic              sat_en,
    input  logic              frac_en,
    input  logic              narrow_op,
    input  logic              top_ready,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [RES_W-1:0]  acc_fb
);

    localparam int NARROW_W = WORD_W * NARROW_WORDS;

    mode_t             mode;
    logic [RES_W-1:0]  frac_view;
    logic [RES_W-1:0]  rd_clamped  [2];
    logic [RES_W-1:0]  acc_clamped [2];
    logic              wait_top;
    logic [RES_W-1:0]  rd_view;
    logic [RES_W-1:0]  acc_view;
    logic [WORD_W-1:0] picked;

    assign mode      = '{sat: sat_en, frac: frac_en, narrow: narrow_op};
    assign frac_view = mode.frac ? {raw_res[RES_W-2:0], 1'b0} : raw_res;

    // One clamp unit per width: index 0 narrow, index 1 full
    for (genvar g = 0; g < 2; g++) begin : g_width
        localparam int GW = (g == 0) ? NARROW_W : RES_W;
        logic [GW-1:0] rd_c;
        logic [GW-1:0] acc_c;

        res_clamp #(.W(GW)) u_clamp (
            .unshifted (raw_res[GW-1:0]),
            .view_in   (frac_view[GW-1:0]),
            .carry     (carry_in),
            .frac      (mode.frac),
            .rd_out    (rd_c),
            .acc_out   (acc_c)
        );

        assign rd_clamped[g]  = RES_W'(rd_c);
        assign acc_clamped[g] = RES_W'(acc_c);
    end

    assign wait_top = mode.sat && !mode.narrow && !top_ready;

    always_comb begin
        if (!mode.sat) begin
            rd_view  = frac_view;
            acc_view = raw_res;
        end else if (wait_top) begin
            rd_view  = raw_res;
            acc_view = raw_res;
        end else if (mode.narrow) begin
            rd_view  = {frac_view[RES_W-1:NARROW_W], rd_clamped[0][NARROW_W-1:0]};
            acc_view = {raw_res[RES_W-1:NARROW_W], acc_clamped[0][NARROW_W-1:0]};
        end else begin
            rd_view  = rd_clamped[1];
            acc_view = acc_clamped[1];
        end
    end

    res_word_pick #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS),
        .SEL_W     (SEL_W)
    ) u_pick (
        .view (rd_view),
        .sel  (rd_sel),
        .word (picked)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            acc_fb   <= '0;
        end else begin
            rd_data  <= picked;
            rd_valid <= !wait_top;
            acc_fb   <= acc_view;
        end
    end

endmodule

// File: rtl/res_sat_view_checker.sv
module res_sat_view_checker #(
    parameter int WORD_W    = 16,
    parameter int NUM_WORDS = 4,
    parameter int SEL_W     = 2
) (
    input logic                        clk,
    input logic                        rst,
    input logic [WORD_W*NUM_WORDS-1:0] raw_res,
    input logic                        carry_in,
    input logic                        sat_en,
    input logic                        frac_en,
    input logic                        narrow_op,
    input logic                        top_ready,
    input logic [SEL_W-1:0]            rd_sel,
    input logic [WORD_W-1:0]           rd_data,
    input logic                        rd_valid,
    input logic [WORD_W*NUM_WORDS-1:0] acc_fb
);

    localparam int RES_W = WORD_W * NUM_WORDS;
    localparam logic [SEL_W-1:0] TOP_SEL = SEL_W'(NUM_WORDS - 1);

    a_r1_raw_pass: assert property (@(posedge clk) disable iff (rst)
        (!sat_en && !frac_en && rd_sel == '0)
        |=> (rd_data == $past(raw_res[WORD_W-1:0]) && rd_valid && acc_fb == $past(raw_res)));

    a_r2_frac_shift: assert property (@(posedge clk) disable iff (rst)
        (!sat_en && frac_en && rd_sel == '0)
        |=> (rd_data == {$past(raw_res[WORD_W-2:0]), 1'b0}));

    a_r3_pos_clamp: assert property (@(posedge clk) disable iff (rst)
        (sat_en && !narrow_op && top_ready && !carry_in && raw_res[RES_W-1] && rd_sel == TOP_SEL)
        |=> (rd_data == {1'b0, {(WORD_W-1){1'b1}}}));

    a_r4_neg_clamp: assert property (@(posedge clk) disable iff (rst)
        (sat_en && !narrow_op && top_ready && carry_in && !raw_res[RES_W-1] && rd_sel == TOP_SEL)
        |=> (rd_data == {1'b1, {(WORD_W-1){1'b0}}}));

    a_r7_acc_in_range: assert property (@(posedge clk) disable iff (rst)
        (sat_en && !narrow_op && top_ready && (carry_in == raw_res[RES_W-1]))
        |=> (acc_fb == $past(raw_res)));

    a_r8_wait_top: assert property (@(posedge clk) disable iff (rst)
        (sat_en && !narrow_op && !top_ready)
        |=> (!rd_valid && acc_fb == $past(raw_res)));

    a_r8_narrow_valid: assert property (@(posedge clk) disable iff (rst)
        (narrow_op) |=> rd_valid);

    a_r9_reset: assert property (@(posedge clk)
        rst |=> (rd_data == '0 && !rd_valid && acc_fb == '0));

endmodule

bind res_sat_view res_sat_view_checker #(
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS),
    .SEL_W     (SEL_W)
) u_res_sat_view_checker (
    .clk       (clk),
    .rst       (rst),
    .raw_res   (raw_res),
    .carry_in  (carry_in),
    .sat_en    (sat_en),
    .frac_en   (frac_en),
    .narrow_op (narrow_op),
    .top_ready (top_ready),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .acc_fb    (acc_fb)
);

// File: tb/res_sat_view_bench.sv
module res_sat_view_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] raw_res = '0;
    logic        carry_in = 1'b0;
    logic        sat_en = 1'b0;
    logic        frac_en = 1'b0;
    logic        narrow_op = 1'b0;
    logic        top_ready = 1'b0;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic [63:0] acc_fb;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    res_sat_view u_res_sat_view (
        .clk       (clk),
        .rst       (rst),
        .raw_res   (raw_res),
        .carry_in  (carry_in),
        .sat_en    (sat_en),
        .frac_en   (frac_en),
        .narrow_op (narrow_op),
        .top_ready (top_ready),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .acc_fb    (acc_fb)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply inputs at a falling edge, then wait to the next falling edge
    task automatic put(input logic [63:0] r, input logic c, input logic s, input logic f,
                       input logic n, input logic t, input logic [1:0] sel);
        raw_res = r; carry_in = c; sat_en = s; frac_en = f;
        narrow_op = n; top_ready = t; rd_sel = sel;
        @(negedge clk);
    endtask

    // Walk all four words of the present setup and compare
    task automatic read_words(input string req, input logic [63:0] r, input logic c,
                              input logic s, input logic f, input logic n, input logic t,
                              input logic [63:0] exp_view);
        for (int k = 0; k < 4; k++) begin
            put(r, c, s, f, n, t, 2'(k));
            chk(req, {48'd0, rd_data}, {48'd0, exp_view[k*16 +: 16]});
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        put(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd3);
        chk("R9 rd_data", {48'd0, rd_data}, 64'd0);
        chk("R9 rd_valid", {63'd0, rd_valid}, 64'd0);
        chk("R9 acc_fb", acc_fb, 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_raw;
        read_words("R1 raw words", 64'h8123_4567_89AB_CDEF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                   64'h8123_4567_89AB_CDEF);
        chk("R1 acc_fb", acc_fb, 64'h8123_4567_89AB_CDEF);
        chk("R8 valid with sat off", {63'd0, rd_valid}, 64'd1);
    endtask

    task automatic t_frac_only;
        read_words("R2 shifted words", 64'h4000_0000_8000_0001, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1,
                   64'h8000_0001_0000_0002);
        chk("R2 acc_fb unshifted", acc_fb, 64'h4000_0000_8000_0001);
    endtask

    task automatic t_wide_clamp;
        read_words("R3 wide positive", 64'h8000_0000_0000_1234, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1,
                   64'h7FFF_FFFF_FFFF_FFFF);
        chk("R7 acc wide positive", acc_fb, 64'h7FFF_FFFF_FFFF_FFFF);
        read_words("R4 wide negative", 64'h7000_0000_0000_0001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1,
                   64'h8000_0000_0000_0000);
        chk("R7 acc wide negative", acc_fb, 64'h8000_0000_0000_0000);
        read_words("R3 positive in frac mode", 64'h8000_0000_0000_1234, 1'b0, 1'b1, 1'b1, 1'b0,
                   1'b1, 64'h7FFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_frac_clamp;
        read_words("R5 top bits 01", 64'h4000_0000_0000_0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1,
                   64'h7FFF_FFFF_FFFF_FFFF);
        chk("R7 acc ignores frac 01", acc_fb, 64'h4000_0000_0000_0000);
        read_words("R5 top bits 10", 64'hA000_0000_0000_0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1,
                   64'h8000_0000_0000_0000);
        chk("R7 acc ignores frac 10", acc_fb, 64'hA000_0000_0000_0000);
        read_words("R5 in range shifted", 64'h2000_0000_0000_0003, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1,
                   64'h4000_0000_0000_0006);
    endtask

    task automatic t_narrow;
        // Low 32 bits 0x8000_059F, carry 0, sat and frac on
        read_words("R6 narrow overflow", 64'h0000_0000_8000_059F, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1,
                   64'h0000_0001_7FFF_FFFF);
        chk("R7 acc narrow", acc_fb, 64'h0000_0000_7FFF_FFFF);
        // -1.0 x -1.0 gives 0x4000_0000
        read_words("R5 narrow minus one squared", 64'h0000_0000_4000_0000, 1'b0, 1'b1, 1'b1,
                   1'b1, 1'b1, 64'h0000_0000_7FFF_FFFF);
        chk("R7 acc minus one squared", acc_fb, 64'h0000_0000_4000_0000);
        read_words("R6 narrow negative upper raw", 64'h1234_5678_7FFF_0000, 1'b1, 1'b1, 1'b0,
                   1'b1, 1'b0, 64'h1234_5678_8000_0000);
        chk("R8 narrow ignores top_ready", {63'd0, rd_valid}, 64'd1);
        chk("R7 acc narrow negative", acc_fb, 64'h1234_5678_8000_0000);
    endtask

    task automatic t_wait_top;
        put(64'h8000_0000_0000_1234, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3);
        chk("R8 valid low while waiting", {63'd0, rd_valid}, 64'd0);
        chk("R8 raw word while waiting", {48'd0, rd_data}, 64'h8000);
        chk("R8 acc raw while waiting", acc_fb, 64'h8000_0000_0000_1234);
        put(64'h8000_0000_0000_1234, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd3);
        chk("R8 valid after top ready", {63'd0, rd_valid}, 64'd1);
        chk("R8 clamped after top ready", {48'd0, rd_data}, 64'h7FFF);
    endtask

    task automatic t_toggle;
        put(64'h8000_0000_0000_1234, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd3);
        chk("R10 sat on", {48'd0, rd_data}, 64'h7FFF);
        put(64'h8000_0000_0000_1234, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3);
        chk("R10 sat off", {48'd0, rd_data}, 64'h8000);
        put(64'h8000_0000_0000_1234, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0);
        chk("R10 frac on", {48'd0, rd_data}, 64'h2468);
        put(64'h8000_0000_0000_1234, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0);
        chk("R10 sat on again", {48'd0, rd_data}, 64'hFFFF);
    endtask

    initial begin
        @(negedge clk);
        t_reset;
        t_raw;
        t_frac_only;
        t_wide_clamp;
        t_frac_clamp;
        t_narrow;
        t_wait_top;
        t_toggle;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule